// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between an 8-bit microcontroller core and its data memory. Each cycle the core presents a 7-bit register-file operand offset together with a write enable and write data. The unit turns that operand into a physical location and serves the access. The read data is combinational, and writes commit on the rising clock edge.

There are two address paths. A direct access takes its two bank bits from the status register. An operand of 00h selects an indirect access. An indirect access takes its offset and the low bank bit from an 8-bit pointer register, and the high bank bit from a separate status bit.

The physical storage is laid out so that several bank addresses reach the same cell:
- The top sixteen offsets of every bank share one set of sixteen cells.
- The status register and the pointer each exist once, and every bank reaches the same copy.
- The general-purpose area is separate in each of the four banks.

All other low offsets belong to peripheral registers outside the block. Those accesses leave through an external port that carries the offset and the resolved bank. For the three mirrored external offsets, the bank on that port is forced to zero.

Top module: `bank_mem_unit`

## Requirements
- R1: Reset clears the status register (bit 7 indirect bank bit, bit 6 and bit 5 direct bank bits) and the pointer to 00h, so the first direct access targets bank 0.
- R2: An operand other than 00h is a direct access: bank = {status[6], status[5]}, offset = operand.
- R3: Operand 00h is an indirect access: bank = {status[7], pointer[7]}, offset = pointer[6:0].
- R4: An indirect access whose pointer offset is 00h reads 00h, and its write changes no storage and raises no external write.
- R5: Offsets 70h to 7Fh reach the same sixteen cells whatever the bank.
- R6: Offsets 20h to 6Fh are separate storage in each of the four banks.
- R7: Offset 03h (status) and offset 04h (pointer) reach one register each from every bank, and all 8 bits read back as written.
- R8: Offsets 01h to 1Fh other than 03h and 04h raise ext_sel, put the offset on ext_addr and the resolved bank on ext_bank, return ext_rd_data as rd_data, and give ext_wr_en = wr_en.
- R9: For external offsets 02h, 0Ah and 0Bh, ext_bank is 00 in every bank.
- R10: Reads follow the operand in the same cycle. Writes take effect at the next rising edge, and a status write changes the bank starting with the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_addr | input | 7 | Operand offset from the instruction; 00h selects indirect |
| wr_en | input | 1 | Write the resolved location at the next edge |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Combinational read data of the resolved location |
| ext_sel | output | 1 | Resolved location is an external peripheral register |
| ext_wr_en | output | 1 | Write strobe for the external register |
| ext_addr | output | 7 | Offset of the external register |
| ext_bank | output | 2 | Bank of the external register (00 for mirrored ones) |
| ext_wr_data | output | 8 | Write data for the external register |
| ext_rd_data | input | 8 | Read data returned by the external register |

## Verification
The hardest case to reach from the ports is an access whose location depends on earlier writes. This covers an indirect access into a high bank, which needs the indirect bank bit set and a pointer with bit 7 set, and the self-referencing indirect access, which needs the pointer offset cleared first. The stimulus fills every banked cell through direct writes and then drives directed sequences that set up these states. After that it runs a long random phase that is biased toward writes of the status register and the pointer and toward operand 00h. Through that phase the bank-select state keeps changing while a bench model tracks the expected contents.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int DW     = 8;
    localparam int NBANK  = 4;
    localparam int IRP_B  = 7;
    localparam int RP1_B  = 6;
    localparam int RP0_B  = 5;
    localparam logic [6:0] OFF_INDIRECT = 7'h00;
    localparam logic [6:0] OFF_STATUS   = 7'h03;
    localparam logic [6:0] OFF_POINTER  = 7'h04;

    typedef enum logic [2:0] {
        RG_NULL, RG_STATUS, RG_PTR, RG_EXT, RG_GPR, RG_COMMON
    } region_e;

    typedef struct packed {
        logic [DW-1:0] status;
        logic [DW-1:0] ptr;
    } sfr_t;

    function automatic logic ext_mirrored(input logic [6:0] off);
        return (off == 7'h02) || (off == 7'h0A) || (off == 7'h0B);
    endfunction
endpackage

// File: rtl/bmu_resolve.sv
module bmu_resolve
    import bmu_pkg::*;
#(
    parameter int unsigned OFF_W       = 7,
    parameter int unsigned GPR_BASE    = 32,
    parameter int unsigned COMMON_BASE = 112
) (
    input  logic [OFF_W-1:0] op_addr,
    input  logic [DW-1:0]    status,
    input  logic [DW-1:0]    ptr,
    output region_e          region,
    output logic [1:0]       bank,
    output logic [OFF_W-1:0] off,
    output logic [1:0]       ext_bank
);
    localparam logic [OFF_W-1:0] GB = OFF_W'(GPR_BASE);
    localparam logic [OFF_W-1:0] CB = OFF_W'(COMMON_BASE);

    logic indirect;

    always_comb begin
        indirect = (op_addr == OFF_INDIRECT);
        if (indirect) begin
            bank = {status[IRP_B], ptr[DW-1]};
            off  = ptr[OFF_W-1:0];
        end else begin
            bank = {status[RP1_B], status[RP0_B]};
            off  = op_addr;
        end

        if (indirect && off == OFF_INDIRECT) region = RG_NULL;
        else if (off >= CB)                  region = RG_COMMON;
        else if (off >= GB)                  region = RG_GPR;
        else if (off == OFF_STATUS)          region = RG_STATUS;
        else if (off == OFF_POINTER)         region = RG_PTR;
        else                                 region = RG_EXT;

        ext_bank = ext_mirrored(off) ? 2'b00 : bank;
    end
endmodule

// File: rtl/bmu_sfr.sv
module bmu_sfr
    import bmu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_status,
    input  logic          we_ptr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] status_q,
    output logic [DW-1:0] ptr_q
);
    sfr_t sfr_d, sfr_q;

    always_comb begin
        sfr_d = sfr_q;
        if (we_status) sfr_d.status = wdata;
        if (we_ptr)    sfr_d.ptr    = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sfr_q <= '0;
        else        sfr_q <= sfr_d;
    end

    assign status_q = sfr_q.status;
    assign ptr_q    = sfr_q.ptr;
endmodule

// File: rtl/bmu_gpr.sv
module bmu_gpr
    import bmu_pkg::*;
#(
    parameter int unsigned OFF_W       = 7,
    parameter int unsigned GPR_BASE    = 32,
    parameter int unsigned COMMON_BASE = 112
) (
    input  logic             clk,
    input  logic             we_gpr,
    input  logic             we_com,
    input  logic [1:0]       bank,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_gpr,
    output logic [DW-1:0]    rd_com
);
    localparam int BANK_GPR = COMMON_BASE - GPR_BASE;
    localparam int GPR_N    = NBANK * BANK_GPR;
    localparam int COM_N    = (1 << OFF_W) - COMMON_BASE;
    localparam int GI_W     = $clog2(GPR_N);
    localparam int CI_W     = $clog2(COM_N);
    localparam logic [OFF_W-1:0] GB = OFF_W'(GPR_BASE);
    localparam logic [OFF_W-1:0] CB = OFF_W'(COMMON_BASE);

    logic [DW-1:0]   gpr_mem [GPR_N];
    logic [DW-1:0]   com_mem [COM_N];
    logic [GI_W-1:0] gidx;
    logic [CI_W-1:0] cidx;

    always_comb begin
        gidx   = GI_W'(bank) * GI_W'(BANK_GPR) + GI_W'(off - GB);
        cidx   = CI_W'(off - CB);
        rd_gpr = gpr_mem[gidx];
        rd_com = com_mem[cidx];
    end

    always_ff @(posedge clk) begin
        if (we_gpr) gpr_mem[gidx] <= wdata;
        if (we_com) com_mem[cidx] <= wdata;
    end
endmodule

// File: rtl/bank_mem_unit.sv
module bank_mem_unit
    import bmu_pkg::*;
#(
    parameter int unsigned OFF_W       = 7,
    parameter int unsigned GPR_BASE    = 32,
    parameter int unsigned COMMON_BASE = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] op_addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output logic             ext_sel,
    output logic             ext_wr_en,
    output logic [OFF_W-1:0] ext_addr,
    output logic [1:0]       ext_bank,
    output logic [DW-1:0]    ext_wr_data,
    input  logic [DW-1:0]    ext_rd_data
);
    logic [DW-1:0]    status_q, ptr_q, rd_gpr, rd_com;
    region_e          region;
    logic [1:0]       bank, eff_ext_bank;
    logic [OFF_W-1:0] off;

    bmu_resolve #(.OFF_W(OFF_W), .GPR_BASE(GPR_BASE), .COMMON_BASE(COMMON_BASE)) u_res (
        .op_addr(op_addr), .status(status_q), .ptr(ptr_q),
        .region(region), .bank(bank), .off(off), .ext_bank(eff_ext_bank)
    );

    bmu_sfr u_sfr (
        .clk(clk), .rst_n(rst_n),
        .we_status(wr_en && region == RG_STATUS),
        .we_ptr(wr_en && region == RG_PTR),
        .wdata(wr_data), .status_q(status_q), .ptr_q(ptr_q)
    );

    bmu_gpr #(.OFF_W(OFF_W), .GPR_BASE(GPR_BASE), .COMMON_BASE(COMMON_BASE)) u_gpr (
        .clk(clk),
        .we_gpr(wr_en && region == RG_GPR),
        .we_com(wr_en && region == RG_COMMON),
        .bank(bank), .off(off), .wdata(wr_data),
        .rd_gpr(rd_gpr), .rd_com(rd_com)
    );

    always_comb begin
        unique case (region)
            RG_STATUS: rd_data = status_q;
            RG_PTR:    rd_data = ptr_q;
            RG_EXT:    rd_data = ext_rd_data;
            RG_GPR:    rd_data = rd_gpr;
            RG_COMMON: rd_data = rd_com;
            default:   rd_data = '0;
        endcase
    end

    assign ext_sel     = (region == RG_EXT);
    assign ext_wr_en   = ext_sel && wr_en;
    assign ext_addr    = off;
    assign ext_bank    = eff_ext_bank;
    assign ext_wr_data = wr_data;
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk
    import bmu_pkg::*;
#(
    parameter int unsigned OFF_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFF_W-1:0] op_addr,
    input logic             wr_en,
    input logic [DW-1:0]    wr_data,
    input logic [DW-1:0]    rd_data,
    input logic             ext_sel,
    input logic             ext_wr_en,
    input logic [OFF_W-1:0] ext_addr,
    input logic [1:0]       ext_bank,
    input logic [DW-1:0]    status_q,
    input logic [DW-1:0]    ptr_q
);
    logic self_ind;
    assign self_ind = (op_addr == '0) && (ptr_q[OFF_W-1:0] == '0);

    AST_SELF_INDIRECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        self_ind |-> (rd_data == '0 && !ext_wr_en)); // R4
    AST_SELF_INDIRECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ind && wr_en) |=> (status_q == $past(status_q) && ptr_q == $past(ptr_q))); // R4
    AST_STATUS_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_addr == OFF_STATUS) |=> (status_q == $past(wr_data))); // R10
    AST_MIRROR_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && ext_mirrored(ext_addr)) |-> (ext_bank == 2'b00)); // R9
    AST_EXT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> (ext_addr <= 7'h1F && ext_addr != OFF_INDIRECT
                     && ext_addr != OFF_STATUS && ext_addr != OFF_POINTER)); // R8
    AST_COMMON_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_addr >= 7'h70) |-> !ext_sel); // R5
endmodule

bind bank_mem_unit bmu_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_bank_mem_unit.sv
module tb_bank_mem_unit;
    localparam int CLK_P = 10;

    logic       clk = 0, rst_n = 0, wr_en = 0;
    logic [6:0] op_addr = 7'h10;
    logic [7:0] wr_data = 0, rd_data, ext_wr_data, ext_rd_data;
    logic       ext_sel, ext_wr_en;
    logic [6:0] ext_addr;
    logic [1:0] ext_bank;

    int nvec = 0, nerr = 0;

    logic [7:0] m_st, m_ptr;
    logic [7:0] m_gpr [4][80];
    logic [7:0] m_com [16];

    always #(CLK_P/2) clk = ~clk;

    assign ext_rd_data = {ext_bank, ext_addr[5:0]} ^ 8'hA5;

    bank_mem_unit dut (.*);

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic acc(input logic [6:0] a, input logic we, input logic [7:0] d);
        logic [1:0] b, eb;
        logic [6:0] o;
        logic ind, xs;
        logic [7:0] er;
        string tag;
        @(negedge clk);
        op_addr = a; wr_en = we; wr_data = d;
        #(CLK_P/4);
        ind = (a == 0);
        b = ind ? {m_st[7], m_ptr[7]} : m_st[6:5];
        o = ind ? m_ptr[6:0] : a;
        xs = 0;
        if (ind && o == 0) begin er = 0; tag = "R4"; end
        else if (o >= 7'h70) begin er = m_com[o-7'h70]; tag = "R5"; if (we) m_com[o-7'h70] = d; end
        else if (o >= 7'h20) begin er = m_gpr[b][o-7'h20]; tag = ind ? "R3" : "R6"; if (we) m_gpr[b][o-7'h20] = d; end
        else if (o == 3) begin er = m_st; tag = "R7"; if (we) m_st = d; end
        else if (o == 4) begin er = m_ptr; tag = "R7"; if (we) m_ptr = d; end
        else begin
            xs = 1;
            eb = (o == 2 || o == 7'h0A || o == 7'h0B) ? 2'b00 : b;
            tag = (eb != b) ? "R9" : "R8";
            er = {eb, o[5:0]} ^ 8'hA5;
            chk(tag, {7'd0, ext_wr_en}, {7'd0, we});
            chk(tag, {1'b0, ext_addr}, {1'b0, o});
            chk(tag, {6'd0, ext_bank}, {6'd0, eb});
            if (we) chk(tag, ext_wr_data, d);
        end
        chk(tag, {7'd0, ext_sel}, {7'd0, xs});
        if (^er !== 1'bx) chk(tag, rd_data, er);
    endtask

    initial begin
        #(CLK_P * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        m_st = 0; m_ptr = 0;
        foreach (m_gpr[i, j]) m_gpr[i][j] = 'x;
        foreach (m_com[i]) m_com[i] = 'x;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: status and pointer cleared, bank 0 selected
        acc(7'h03, 0, 0);
        acc(7'h04, 0, 0);
        acc(7'h05, 0, 0);
        // fill banked area per bank (R2 direct bank select), common area once
        for (int bk = 0; bk < 4; bk++) begin
            acc(7'h03, 1, 8'(bk << 5));
            for (int o = 32; o < 112; o++) acc(7'(o), 1, 8'($urandom));
        end
        for (int o = 112; o < 128; o++) acc(7'(o), 1, 8'($urandom));
        // R5: write common from bank 2, read from bank 1
        acc(7'h03, 1, 8'h40); acc(7'h75, 1, 8'h3C);
        acc(7'h03, 1, 8'h20); acc(7'h75, 0, 0);
        // R6: same offset, different banks
        for (int bk = 0; bk < 4; bk++) begin
            acc(7'h03, 1, 8'(bk << 5)); acc(7'h40, 0, 0);
        end
        // R7: status written from bank 3, read in bank 0
        acc(7'h03, 1, 8'h7F); acc(7'h03, 1, 8'h1F); acc(7'h04, 0, 0);
        // R3: indirect into bank 3 offset 25h
        acc(7'h03, 1, 8'h80); acc(7'h04, 1, 8'hA5); acc(7'h00, 1, 8'h99); acc(7'h00, 0, 0);
        // R4: self-referencing indirect
        acc(7'h04, 1, 8'h80); acc(7'h00, 1, 8'h77); acc(7'h03, 0, 0); acc(7'h04, 0, 0);
        // R8 / R9: external in bank 2
        acc(7'h03, 1, 8'h40); acc(7'h02, 1, 8'h11); acc(7'h0A, 0, 0); acc(7'h05, 1, 8'h22);
        // R10: bank switch effective on the very next access
        acc(7'h03, 1, 8'h60); acc(7'h30, 0, 0);
        for (int k = 0; k < 3000; k++) begin
            int r;
            logic [6:0] a;
            r = int'($urandom_range(99));
            a = (r < 20) ? 7'h03 : (r < 35) ? 7'h04 : (r < 55) ? 7'h00 : 7'($urandom);
            acc(a, 1'($urandom), 8'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule